// File: doc/BRIEF.md
# Readout Protection Level Controller

This block keeps a three-level readout-protection state for a chip and decides, one access at a time, whether a memory request is answered with a grant or with a bus error. The answer depends on the protection level, on the boot source, on whether the request comes from the debug port or from user code, and on the target region. The flash array and the secondary SRAM are the protected regions. Main SRAM and peripheral space are unprotected.

The level is kept as an 8-bit option byte in non-volatile storage outside the block. While reset is held, the block loads that byte from `nv_byte_in`. When the level changes, it sends the new byte out on `nv_byte_out` together with a one-cycle `nv_commit` strobe.

The level can be raised at any time. There is one way to lower it, from level 1 to level 0, and that path first runs a mass erase through an `erase_req`/`erase_done` handshake. The erase engine clears flash, the secondary SRAM and the backup registers.

At level 2 the following hold:
- the option configuration is frozen;
- the JTAG, trace and boundary-scan enables are forced off;
- every level-change request is ignored.

The controller has four states:
- `ST_OPEN`: level 0.
- `ST_PROT`: level 1.
- `ST_LOCK`: level 2.
- `ST_WIPE`: erase in progress, reported as level 1.

Its transitions are:
- `ST_OPEN` to `ST_PROT`: raise request to 1.
- `ST_OPEN` to `ST_LOCK`: raise request to 2.
- `ST_PROT` to `ST_LOCK`: raise request to 2.
- `ST_PROT` to `ST_WIPE`: lower request to 0.
- `ST_WIPE` to `ST_OPEN`: on `erase_done`.
- Any state: reset reloads the state from the stored byte.

`ST_LOCK` has no exit.

Top module: `rdp_level_ctrl`

## Requirements
- R1: While `rst_n` is low, the stored byte on `nv_byte_in` decides the level: 0xAA gives level 0, 0xCC gives level 2, and any other value gives level 1. `level_out` shows 0, 1 or 2, and shows 1 during an erase.
- R2: At level 0, every access to any region from any source, under any boot source, is granted.
- R3: At level 1, a debug access (`acc_dbg`=1) to flash (`acc_region`=0) or to secondary SRAM (`acc_region`=1) gets `acc_err`, whatever the boot source.
- R4: At level 1, a user-code access to a protected region is granted only when `boot_src`=0 (flash); boot values 1 and 2 (SRAM, system loader) give an error. Regions 2 and 3 are always granted.
- R5: At level 2, every debug access gets an error and user code follows the R4 rule. `opt_frozen`=1 and `dbg_if_en`=3'b000; at levels 0 and 1 these are 0 and 3'b111.
- R6: A raise request (`chg_req` with `chg_level` above the current level, value 1 or 2) is taken at once. In the next cycle, `nv_commit` is high for one cycle with byte 0x55 for level 1 or 0xCC for level 2.
- R7: A request for level 0 while at level 1 raises `erase_req` from the next cycle. The level is not committed until the cycle in which `erase_done` is seen. After that cycle the level is 0 and `nv_commit` carries 0xAA.
- R8: During an erase, every access to a protected region gets an error, unprotected regions are granted, and level-change requests are ignored.
- R9: At level 2, every change request is ignored: no commit is made and the level stays 2.
- R10: A reset during an erase leaves the level at 1, because no byte was committed.
- R11: `acc_grant` or `acc_err` is high for exactly one cycle, the cycle after `acc_req`. The two are never high together, and both are low after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the stored level |
| nv_byte_in | input | 8 | Option byte read from non-volatile storage |
| chg_req | input | 1 | Level-change request strobe |
| chg_level | input | 2 | Requested level |
| boot_src | input | 2 | Boot source: 0 flash, 1 SRAM, 2 system loader |
| acc_req | input | 1 | Access request valid |
| acc_dbg | input | 1 | 1 when the access comes from the debug port |
| acc_region | input | 2 | Target: 0 flash, 1 secondary SRAM, 2 main SRAM, 3 peripherals |
| erase_done | input | 1 | Erase engine finished |
| acc_grant | output | 1 | Access granted, one cycle after the request |
| acc_err | output | 1 | Bus error, one cycle after the request |
| erase_req | output | 1 | Mass-erase request, held until done |
| nv_commit | output | 1 | One-cycle strobe to write `nv_byte_out` to storage |
| nv_byte_out | output | 8 | Option byte to store |
| level_out | output | 2 | Current protection level |
| opt_frozen | output | 1 | Option configuration frozen |
| dbg_if_en | output | 3 | Enables for JTAG, trace and boundary scan |

## Verification
Access responses, `nv_commit` and the new level all appear one cycle after the clock edge that samples the request. `erase_req` rises in the cycle after the lowering request. The bench drives inputs on the falling edge. On each rising edge a behavioural model steps forward using the same inputs. On the next falling edge every output is compared with that model, so each result is checked in the cycle it is due. The bench also keeps its own copy of the stored byte, taken from the model's commits, and feeds it back through reset; this is how the behaviour across reset and during an erase is checked.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_PROT = 2'd1,
        ST_LOCK = 2'd2,
        ST_WIPE = 2'd3
    } rdp_state_t;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] BOOT_FLASH = 2'd0;
    localparam logic [SEL_W-1:0] RGN_FLASH  = 2'd0;
    localparam logic [SEL_W-1:0] RGN_SRAM2  = 2'd1;
endpackage

// File: rtl/rdp_opt_decode.sv
module rdp_opt_decode
    import rdp_pkg::*;
#(
    parameter int             OPT_W     = 8,
    parameter logic [OPT_W-1:0] OPEN_CODE = 8'hAA,
    parameter logic [OPT_W-1:0] LOCK_CODE = 8'hCC
) (
    input  logic [OPT_W-1:0] opt_byte,
    output rdp_state_t       boot_state
);
    always_comb begin
        if (opt_byte == OPEN_CODE)      boot_state = ST_OPEN;
        else if (opt_byte == LOCK_CODE) boot_state = ST_LOCK;
        else                            boot_state = ST_PROT;
    end
endmodule

// File: rtl/rdp_level_fsm.sv
module rdp_level_fsm
    import rdp_pkg::*;
#(
    parameter int               OPT_W     = 8,
    parameter logic [OPT_W-1:0] OPEN_CODE = 8'hAA,
    parameter logic [OPT_W-1:0] PROT_CODE = 8'h55,
    parameter logic [OPT_W-1:0] LOCK_CODE = 8'hCC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rdp_state_t       boot_state,
    input  logic [OPT_W-1:0] nv_byte_in,
    input  logic             chg_req,
    input  logic [1:0]       chg_level,
    input  logic             erase_done,
    output rdp_state_t       state,
    output logic             erase_req,
    output logic             nv_commit,
    output logic [OPT_W-1:0] nv_byte_out
);
    rdp_state_t       state_nx;
    logic             commit_nx;
    logic [OPT_W-1:0] byte_nx;

    always_comb begin
        state_nx  = state;
        commit_nx = 1'b0;
        byte_nx   = nv_byte_out;
        unique case (state)
            ST_OPEN: begin
                if (chg_req && chg_level == 2'd1) begin
                    state_nx = ST_PROT; commit_nx = 1'b1; byte_nx = PROT_CODE;
                end else if (chg_req && chg_level == 2'd2) begin
                    state_nx = ST_LOCK; commit_nx = 1'b1; byte_nx = LOCK_CODE;
                end
            end
            ST_PROT: begin
                if (chg_req && chg_level == 2'd2) begin
                    state_nx = ST_LOCK; commit_nx = 1'b1; byte_nx = LOCK_CODE;
                end else if (chg_req && chg_level == 2'd0) begin
                    state_nx = ST_WIPE;
                end
            end
            ST_WIPE: begin
                if (erase_done) begin
                    state_nx = ST_OPEN; commit_nx = 1'b1; byte_nx = OPEN_CODE;
                end
            end
            ST_LOCK: begin
                state_nx = ST_LOCK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= boot_state;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_commit   <= 1'b0;
            nv_byte_out <= nv_byte_in;
        end else begin
            nv_commit   <= commit_nx;
            nv_byte_out <= byte_nx;
        end
    end

    assign erase_req = (state == ST_WIPE);

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |=> (state == ST_LOCK && !nv_commit));

    assert_wipe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIPE && !erase_done) |=> (state == ST_WIPE && !nv_commit));

    assert_raise_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && chg_req && chg_level == 2'd2) |=> (state == ST_LOCK && nv_commit && nv_byte_out == LOCK_CODE));
endmodule

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
    import rdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  rdp_state_t       state,
    input  logic [SEL_W-1:0] boot_src,
    input  logic             acc_req,
    input  logic             acc_dbg,
    input  logic [SEL_W-1:0] acc_region,
    output logic             acc_grant,
    output logic             acc_err
);
    logic prot_rgn, deny;

    always_comb begin
        prot_rgn = (acc_region == RGN_FLASH) || (acc_region == RGN_SRAM2);
        unique case (state)
            ST_OPEN: deny = 1'b0;
            ST_PROT: deny = prot_rgn && (acc_dbg || boot_src != BOOT_FLASH);
            ST_LOCK: deny = acc_dbg || (prot_rgn && boot_src != BOOT_FLASH);
            ST_WIPE: deny = prot_rgn;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_grant <= 1'b0;
            acc_err   <= 1'b0;
        end else begin
            acc_grant <= acc_req && !deny;
            acc_err   <= acc_req && deny;
        end
    end

    assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_err));

    assert_resp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !(acc_grant || acc_err));

    assert_wipe_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIPE && acc_req && prot_rgn) |=> acc_err);
endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
    import rdp_pkg::*;
#(
    parameter int               OPT_W     = 8,
    parameter logic [OPT_W-1:0] OPEN_CODE = 8'hAA,
    parameter logic [OPT_W-1:0] PROT_CODE = 8'h55,
    parameter logic [OPT_W-1:0] LOCK_CODE = 8'hCC,
    parameter int               DBG_IFS   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPT_W-1:0]   nv_byte_in,
    input  logic               chg_req,
    input  logic [1:0]         chg_level,
    input  logic [1:0]         boot_src,
    input  logic               acc_req,
    input  logic               acc_dbg,
    input  logic [1:0]         acc_region,
    input  logic               erase_done,
    output logic               acc_grant,
    output logic               acc_err,
    output logic               erase_req,
    output logic               nv_commit,
    output logic [OPT_W-1:0]   nv_byte_out,
    output logic [1:0]         level_out,
    output logic               opt_frozen,
    output logic [DBG_IFS-1:0] dbg_if_en
);
    rdp_state_t boot_state, state;

    rdp_opt_decode #(.OPT_W(OPT_W), .OPEN_CODE(OPEN_CODE), .LOCK_CODE(LOCK_CODE)) u_decode (
        .opt_byte(nv_byte_in), .boot_state(boot_state));

    rdp_level_fsm #(.OPT_W(OPT_W), .OPEN_CODE(OPEN_CODE), .PROT_CODE(PROT_CODE),
                    .LOCK_CODE(LOCK_CODE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_state(boot_state), .nv_byte_in(nv_byte_in),
        .chg_req(chg_req), .chg_level(chg_level), .erase_done(erase_done),
        .state(state), .erase_req(erase_req), .nv_commit(nv_commit),
        .nv_byte_out(nv_byte_out));

    rdp_access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .state(state), .boot_src(boot_src),
        .acc_req(acc_req), .acc_dbg(acc_dbg), .acc_region(acc_region),
        .acc_grant(acc_grant), .acc_err(acc_err));

    always_comb begin
        unique case (state)
            ST_OPEN: level_out = 2'd0;
            ST_LOCK: level_out = 2'd2;
            ST_PROT, ST_WIPE: level_out = 2'd1;
        endcase
    end

    assign opt_frozen = (state == ST_LOCK);
    assign dbg_if_en  = {DBG_IFS{state != ST_LOCK}};

    assert_lock_dbg_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_out == 2'd2 && acc_req && acc_dbg) |=> acc_err);

    assert_lock_ifs_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        opt_frozen |-> (dbg_if_en == '0 && level_out == 2'd2));
endmodule

// File: tb/rdp_level_ctrl_bench.sv
module rdp_level_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nv_store = 8'hAA;
    logic       chg_req = 1'b0;
    logic [1:0] chg_level = 2'd0;
    logic [1:0] boot_src = 2'd0;
    logic       acc_req = 1'b0;
    logic       acc_dbg = 1'b0;
    logic [1:0] acc_region = 2'd0;
    logic       erase_done = 1'b0;
    logic       acc_grant, acc_err, erase_req, nv_commit, opt_frozen;
    logic [7:0] nv_byte_out;
    logic [1:0] level_out;
    logic [2:0] dbg_if_en;

    int checks = 0, fails = 0, cycles = 0;
    bit started = 0;

    int m_lvl = 0;
    bit m_wipe = 0, m_commit = 0, m_gnt = 0, m_err = 0;
    logic [7:0] m_byte = 8'hAA;

    always #10 clk = ~clk;

    rdp_level_ctrl u_rdp_level_ctrl (
        .clk(clk), .rst_n(rst_n), .nv_byte_in(nv_store), .chg_req(chg_req),
        .chg_level(chg_level), .boot_src(boot_src), .acc_req(acc_req),
        .acc_dbg(acc_dbg), .acc_region(acc_region), .erase_done(erase_done),
        .acc_grant(acc_grant), .acc_err(acc_err), .erase_req(erase_req),
        .nv_commit(nv_commit), .nv_byte_out(nv_byte_out), .level_out(level_out),
        .opt_frozen(opt_frozen), .dbg_if_en(dbg_if_en));

    function automatic int decode(input logic [7:0] b);
        if (b == 8'hAA) return 0;
        if (b == 8'hCC) return 2;
        return 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // reference model: steps on each rising edge from the sampled inputs
    always @(posedge clk) begin
        bit prot, deny;
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_lvl = decode(nv_store); m_wipe = 0; m_commit = 0;
            m_byte = nv_store; m_gnt = 0; m_err = 0;
        end else begin
            prot = (acc_region == 2'd0) || (acc_region == 2'd1);
            if (m_wipe)          deny = prot;
            else if (m_lvl == 0) deny = 0;
            else if (m_lvl == 1) deny = prot && (acc_dbg || boot_src != 2'd0);
            else                 deny = acc_dbg || (prot && boot_src != 2'd0);
            m_gnt = acc_req && !deny;
            m_err = acc_req && deny;
            m_commit = 0;
            if (m_wipe) begin
                if (erase_done) begin m_wipe = 0; m_lvl = 0; m_commit = 1; m_byte = 8'hAA; end
            end else if (chg_req) begin
                if (m_lvl == 0 && chg_level == 2'd1) begin m_lvl = 1; m_commit = 1; m_byte = 8'h55; end
                else if (m_lvl < 2 && chg_level == 2'd2) begin m_lvl = 2; m_commit = 1; m_byte = 8'hCC; end
                else if (m_lvl == 1 && chg_level == 2'd0) m_wipe = 1;
            end
        end
    end

    // compare every output away from the rising edge
    always @(negedge clk) begin
        string rtag;
        if (started) begin
            check("R1 level", level_out, m_wipe ? 1 : m_lvl);
            rtag = m_wipe ? "R8 resp" : (m_lvl == 0) ? "R2 resp" :
                   (m_lvl == 2) ? "R5 resp" : (acc_dbg ? "R3 resp" : "R4 resp");
            check({rtag, " grant"}, acc_grant, m_gnt);
            check({rtag, " err"}, acc_err, m_err);
            check("R11 exclusive", acc_grant && acc_err, 0);
            check("R7 erase_req", erase_req, m_wipe);
            check(m_byte == 8'hAA ? "R7 commit" : "R6 commit", nv_commit, m_commit);
            check("R6 byte", nv_byte_out, m_byte);
            check("R5 frozen", opt_frozen, (m_lvl == 2 && !m_wipe));
            check("R5 dbg_if_en", dbg_if_en, (m_lvl == 2 && !m_wipe) ? 0 : 7);
            if (m_commit && rst_n) nv_store = m_byte;
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; tick(2); rst_n = 1; tick(1);
    endtask

    task automatic change(input logic [1:0] lvl);
        chg_req = 1; chg_level = lvl; tick(1); chg_req = 0; tick(1);
    endtask

    task automatic sweep();
        for (int b = 0; b < 3; b++)
            for (int d = 0; d < 2; d++)
                for (int r = 0; r < 4; r++) begin
                    boot_src = 2'(b); acc_dbg = 1'(d); acc_region = 2'(r);
                    acc_req = 1; tick(1);
                end
        acc_req = 0; tick(1);
    endtask

    initial begin
        tick(1);
        // R1: stored 0xAA gives the open level
        nv_store = 8'hAA; do_reset(); check("R1 reset open", level_out, 0);
        sweep();                                   // R2
        change(2'd0);                              // no-op at level 0
        change(2'd1); sweep();                     // R6 0->1, R3/R4 sweep
        change(2'd0);                              // R7 start erase
        check("R7 erase pending", erase_req, 1);
        sweep();                                   // R8 during erase
        change(2'd2);                              // R8 ignored during erase
        check("R8 change ignored", level_out, 1);
        erase_done = 1; tick(1); erase_done = 0; tick(1);
        check("R7 lowered", level_out, 0);
        sweep();
        change(2'd1); change(2'd0); tick(3);       // erase again
        do_reset();                                // R10 reset mid-erase
        check("R10 level after reset", level_out, 1);
        check("R10 erase dropped", erase_req, 0);
        change(2'd2); sweep();                     // R6 1->2, R5
        change(2'd0); change(2'd1);                // R9 ignored
        check("R9 stays locked", level_out, 2);
        do_reset();
        check("R9 lock survives reset", level_out, 2);
        nv_store = 8'h00; do_reset();
        check("R1 other byte decodes to 1", level_out, 1);
        nv_store = 8'hAA; do_reset(); change(2'd2); // R6 0->2
        check("R6 direct lock", level_out, 2);
        sweep();
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule